// File: doc/BRIEF.md
# Selectable-Tap Clock Prescaler

This block turns the oscillator clock into a set of divided clock enables for five consumers: timer 1, timer 2, the serial shift clock, the A/D control clock and a clock output pin. The oscillator clock is first divided into an instruction-cycle strobe that fires once every six clocks. A binary ripple counter advances on that strobe, and each of its bits is a tap with ratio 1/2, 1/4 and so on up to 1/4096 of the instruction rate. Each consumer receives a single-cycle enable pulse in the oscillator domain whenever its chosen tap bit goes from 0 to 1.

Every consumer has its own 4-bit ratio code, which is held static after initialisation. Timer 2 and the serial shift clock each have a select bit that the program may change at run time. When it is set, that consumer is driven instead by the rising edges of an external clock pin. The A/D control clock has the same option, but its selection is a static configuration input. External clocks are synchronised through two flip-flops and edge-detected before use.

Top module: `cycle_tap_divider`

## Requirements
- R1: An internal instruction-cycle strobe fires once every CYC_LEN (default 6) oscillator clocks, and the tap counter advances by one on each strobe only.
- R2: For ratio code n with 1 <= n <= NUM_TAPS (default 12, so code values 1..12, i.e. hex 1..c), the consumer's tick repeats every CYC_LEN * 2^n clocks.
- R3: After synchronous reset is released, the first tick for code n follows the 6*2^(n-1)-th rising clock edge, counting the first edge after release as edge 1.
- R4: Code values 0 and anything above NUM_TAPS (13, 14, 15 with defaults) disable the consumer's internal tick entirely.
- R5: Every tick output is high for exactly one clock at a time.
- R6: The five consumers use independent codes, and each output follows only its own code.
- R7: With the timer 2 external select at 1, timer 2 ticks once per rising edge of its external clock, in the third clock after the edge is presented, and internal taps have no effect; clearing the select at run time restores the internal tap.
- R8: A falling edge of an external clock, or an external level held constant, produces no tick.
- R9: The serial shift clock follows R7 and R8 using its own external clock and run-time select.
- R10: The A/D control clock follows R7 and R8 using its own external clock, selected by the static configuration input.
- R11: While rst_n is low, all tick outputs are 0 and the divide and tap counters are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| t1_code | input | 4 | Timer 1 ratio code |
| t2_code | input | 4 | Timer 2 ratio code |
| sio_code | input | 4 | Serial shift clock ratio code |
| adc_code | input | 4 | A/D control clock ratio code |
| cko_code | input | 4 | Clock output ratio code |
| t2_ext_sel | input | 1 | Run-time select of the external clock for timer 2 |
| t2_ext_clk | input | 1 | Timer 2 external clock (asynchronous) |
| sio_ext_sel | input | 1 | Run-time select of the external shift clock |
| sio_ext_clk | input | 1 | External shift clock (asynchronous) |
| adc_ext_cfg | input | 1 | Static select of the external A/D control clock |
| adc_ext_clk | input | 1 | External A/D control clock pin (asynchronous) |
| t1_tick | output | 1 | Timer 1 clock enable |
| t2_tick | output | 1 | Timer 2 clock enable |
| sio_tick | output | 1 | Serial shift clock enable |
| adc_tick | output | 1 | A/D control clock enable |
| cko_tick | output | 1 | Clock output enable |

## Verification
The bench builds the block with its default parameters: six clocks per instruction cycle and twelve taps. With these values, the slowest ratio, code c, needs about 37,000 clocks to show its first two ticks, so every ratio code can be timed exactly, both for phase after reset and for period. Because the five consumers are measured together in one run with different codes, any crossed wiring between consumers shows up at once. Each external path is driven with a fast internal code, so that a leak from the internal tap would be visible while the external source is selected.

// File: rtl/tapdiv_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the selectable-tap prescaler.
package tapdiv_pkg;
    localparam int CODE_W     = 4;
    localparam int N_CONSUMER = 5;

    // How a consumer may take an external clock instead of a tap.
    typedef enum logic [1:0] {
        EXT_NONE    = 2'd0,   // internal tap only
        EXT_RUNTIME = 2'd1,   // select bit changed by the program
        EXT_STATIC  = 2'd2    // select bit fixed at configuration
    } ext_mode_e;

    // Consumer slots, in the order used inside the top level.
    localparam int SLOT_T1  = 0;
    localparam int SLOT_T2  = 1;
    localparam int SLOT_SIO = 2;
    localparam int SLOT_ADC = 3;
    localparam int SLOT_CKO = 4;
endpackage

// File: rtl/cycle_strobe.sv
`timescale 1ns/1ps
// cycle_strobe: divides the oscillator clock by CYC_LEN and gives a
// one-clock strobe per instruction cycle.
// Assumes CYC_LEN >= 2 and a synchronous active-low reset.
module cycle_strobe #(
    parameter int CYC_LEN = 6
) (
    input  logic clk,
    input  logic rst_n,
    output logic cyc_stb
);
    localparam int CNT_W = (CYC_LEN > 2) ? $clog2(CYC_LEN) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CYC_LEN - 1);

    logic [CNT_W-1:0] phase;

    // Count clock phases inside one instruction cycle, wrapping at LAST.
    always_ff @(posedge clk) begin
        if (!rst_n)             phase <= '0;
        else if (phase == LAST) phase <= '0;
        else                    phase <= phase + 1'b1;
    end

    assign cyc_stb = (phase == LAST);

    // R1
    phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase <= LAST);
    // R1
    stb_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_stb |=> !cyc_stb);
endmodule

// File: rtl/tap_ripple.sv
`timescale 1ns/1ps
// tap_ripple: binary counter advanced by the instruction strobe. For
// each bit it gives a one-clock pulse in the cycle where that bit is
// about to go from 0 to 1 (tap k has ratio 1/2^(k+1)).
// Assumes adv is a single-cycle strobe.
module tap_ripple #(
    parameter int NUM_TAPS = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                adv,
    output logic [NUM_TAPS-1:0] tap_rise
);
    logic [NUM_TAPS-1:0] ripple;

    // Advance the tap counter once per instruction strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)   ripple <= '0;
        else if (adv) ripple <= ripple + 1'b1;
    end

    // A bit rises on the next advance when it is 0 and all lower bits are 1.
    for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap
        if (k == 0) begin : g_lsb
            assign tap_rise[k] = adv && !ripple[0];
        end else begin : g_upper
            assign tap_rise[k] = adv && !ripple[k] && (&ripple[k-1:0]);
        end
    end

    // R1
    one_tap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tap_rise));
    // R1
    lsb_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> (ripple[0] != $past(ripple[0])));
    // R1
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(ripple));
endmodule

// File: rtl/ext_edge_sync.sv
`timescale 1ns/1ps
// ext_edge_sync: two-flop synchroniser for an asynchronous clock pin,
// followed by a rising-edge detector giving a one-clock pulse.
// Assumes the external clock is slower than half the oscillator rate.
module ext_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic meta_q, sync_q, last_q;

    // Synchronise the pin and keep one delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            last_q <= 1'b0;
        end else begin
            meta_q <= async_in;
            sync_q <= meta_q;
            last_q <= sync_q;
        end
    end

    assign rise = sync_q && !last_q;

    // R8
    rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/tap_select.sv
`timescale 1ns/1ps
// tap_select: picks one tap by ratio code (1..NUM_TAPS -> tap 0..NUM_TAPS-1)
// or, when EXT_MODE allows and ext_sel is set, the synchronised rising
// edge of an external clock. The result is registered into tick.
// Assumes code is static; ext_sel may change at any clock.
module tap_select
    import tapdiv_pkg::*;
#(
    parameter int        NUM_TAPS = 12,
    parameter ext_mode_e EXT_MODE = EXT_NONE
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CODE_W-1:0]   code,
    input  logic [NUM_TAPS-1:0] tap_rise,
    input  logic                ext_sel,
    input  logic                ext_in,
    output logic                tick
);
    localparam bit HAS_EXT = (EXT_MODE != EXT_NONE);

    logic code_ok;
    logic tap_hit;
    logic ext_rise;
    logic use_ext;

    // Decode the ratio code into a validity flag and the selected tap pulse.
    always_comb begin
        code_ok = 1'b0;
        tap_hit = 1'b0;
        for (int k = 0; k < NUM_TAPS; k++) begin
            if (code == CODE_W'(k + 1)) begin
                code_ok = 1'b1;
                tap_hit = tap_rise[k];
            end
        end
    end

    ext_edge_sync u_ext (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (HAS_EXT ? ext_in : 1'b0),
        .rise     (ext_rise)
    );

    assign use_ext = HAS_EXT && ext_sel;

    // Register the chosen enable source into the consumer tick.
    always_ff @(posedge clk) begin
        if (!rst_n)       tick <= 1'b0;
        else if (use_ext) tick <= ext_rise;
        else              tick <= code_ok && tap_hit;
    end

    // R5
    tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    // R4
    bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!use_ext && !code_ok) |=> !tick);
    // R7
    ext_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (use_ext && !ext_rise) |=> !tick);
endmodule

// File: rtl/cycle_tap_divider.sv
`timescale 1ns/1ps
// cycle_tap_divider: top level. Divides the oscillator clock into an
// instruction strobe, ripples it through NUM_TAPS binary taps and gives
// five independently selected clock enables. Timer 2 and the serial
// shift clock may switch to an external clock at run time; the A/D clock
// may use an external pin by static configuration.
// Assumes ratio codes and adc_ext_cfg are static after reset.
module cycle_tap_divider
    import tapdiv_pkg::*;
#(
    parameter int CYC_LEN  = 6,
    parameter int NUM_TAPS = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] t1_code,
    input  logic [CODE_W-1:0] t2_code,
    input  logic [CODE_W-1:0] sio_code,
    input  logic [CODE_W-1:0] adc_code,
    input  logic [CODE_W-1:0] cko_code,
    input  logic              t2_ext_sel,
    input  logic              t2_ext_clk,
    input  logic              sio_ext_sel,
    input  logic              sio_ext_clk,
    input  logic              adc_ext_cfg,
    input  logic              adc_ext_clk,
    output logic              t1_tick,
    output logic              t2_tick,
    output logic              sio_tick,
    output logic              adc_tick,
    output logic              cko_tick
);
    logic                   cyc_stb;
    logic [NUM_TAPS-1:0]    tap_rise;
    logic [CODE_W-1:0]      code_arr [N_CONSUMER];
    logic [N_CONSUMER-1:0]  sel_arr;
    logic [N_CONSUMER-1:0]  ext_arr;
    logic [N_CONSUMER-1:0]  tick_arr;

    // Source mode of each consumer slot.
    function automatic ext_mode_e slot_mode(input int s);
        case (s)
            SLOT_T2, SLOT_SIO: return EXT_RUNTIME;
            SLOT_ADC:          return EXT_STATIC;
            default:           return EXT_NONE;
        endcase
    endfunction

    assign code_arr[SLOT_T1]  = t1_code;
    assign code_arr[SLOT_T2]  = t2_code;
    assign code_arr[SLOT_SIO] = sio_code;
    assign code_arr[SLOT_ADC] = adc_code;
    assign code_arr[SLOT_CKO] = cko_code;

    assign sel_arr = {1'b0, adc_ext_cfg, sio_ext_sel, t2_ext_sel, 1'b0};
    assign ext_arr = {1'b0, adc_ext_clk, sio_ext_clk, t2_ext_clk, 1'b0};

    cycle_strobe #(.CYC_LEN(CYC_LEN)) u_cyc (
        .clk     (clk),
        .rst_n   (rst_n),
        .cyc_stb (cyc_stb)
    );

    tap_ripple #(.NUM_TAPS(NUM_TAPS)) u_taps (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (cyc_stb),
        .tap_rise (tap_rise)
    );

    for (genvar s = 0; s < N_CONSUMER; s++) begin : g_slot
        tap_select #(
            .NUM_TAPS (NUM_TAPS),
            .EXT_MODE (slot_mode(s))
        ) u_sel (
            .clk      (clk),
            .rst_n    (rst_n),
            .code     (code_arr[s]),
            .tap_rise (tap_rise),
            .ext_sel  (sel_arr[s]),
            .ext_in   (ext_arr[s]),
            .tick     (tick_arr[s])
        );
    end

    assign t1_tick  = tick_arr[SLOT_T1];
    assign t2_tick  = tick_arr[SLOT_T2];
    assign sio_tick = tick_arr[SLOT_SIO];
    assign adc_tick = tick_arr[SLOT_ADC];
    assign cko_tick = tick_arr[SLOT_CKO];

    // R11
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (tick_arr == '0));
    // R1
    tick_needs_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!cyc_stb) && (sel_arr == '0) && $past(sel_arr == '0)) |-> (tick_arr == '0));
endmodule

// File: tb/cycle_tap_divider_tb.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module cycle_tap_divider_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0] c_t1 = 4'd1, c_t2 = 4'd1, c_sio = 4'd1, c_adc = 4'd1, c_cko = 4'd1;
    logic t2_sel = 1'b0, sio_sel = 1'b0, adc_cfg = 1'b0;
    logic t2_x = 1'b0, sio_x = 1'b0, adc_x = 1'b0;
    logic t1_tk, t2_tk, sio_tk, adc_tk, cko_tk;
    logic [4:0] ticks;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    cycle_tap_divider u_dut (
        .clk(clk), .rst_n(rst_n),
        .t1_code(c_t1), .t2_code(c_t2), .sio_code(c_sio),
        .adc_code(c_adc), .cko_code(c_cko),
        .t2_ext_sel(t2_sel), .t2_ext_clk(t2_x),
        .sio_ext_sel(sio_sel), .sio_ext_clk(sio_x),
        .adc_ext_cfg(adc_cfg), .adc_ext_clk(adc_x),
        .t1_tick(t1_tk), .t2_tick(t2_tk), .sio_tick(sio_tk),
        .adc_tick(adc_tk), .cko_tick(cko_tk)
    );

    assign ticks = {cko_tk, adc_tk, sio_tk, t2_tk, t1_tk};

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic set_ext(input int which, input logic v);
        case (which)
            1: t2_x = v;
            2: sio_x = v;
            default: adc_x = v;
        endcase
    endtask

    // R11: outputs stay low while reset is held, whatever the inputs do.
    task automatic test_reset_quiet();
        int seen = 0;
        c_t1 = 4'd1; c_t2 = 4'd1; c_sio = 4'd1; c_adc = 4'd1; c_cko = 4'd1;
        t2_sel = 1'b1; sio_sel = 1'b0; adc_cfg = 1'b1;
        @(negedge clk);
        rst_n = 1'b0;
        for (int n = 0; n < 40; n++) begin
            t2_x = n[1]; adc_x = n[2];
            @(negedge clk);
            if (ticks != 5'b0) seen++;
        end
        check(seen == 0, "R11 ticks during reset", seen, 0);
        t2_sel = 1'b0; adc_cfg = 1'b0; t2_x = 1'b0; adc_x = 1'b0;
    endtask

    // R1 R2 R3 R4 R5 R6: time first and second tick of every consumer.
    task automatic run_codes(input logic [3:0] a, input logic [3:0] b, input logic [3:0] c,
                             input logic [3:0] d, input logic [3:0] e, input int limit);
        int first [5];
        int second [5];
        int cnt [5];
        int dbl = 0;
        logic [3:0] cd [5];
        logic [4:0] prev = 5'b0;
        cd[0] = a; cd[1] = b; cd[2] = c; cd[3] = d; cd[4] = e;
        c_t1 = a; c_t2 = b; c_sio = c; c_adc = d; c_cko = e;
        t2_sel = 1'b0; sio_sel = 1'b0; adc_cfg = 1'b0;
        for (int i = 0; i < 5; i++) begin first[i] = -1; second[i] = -1; cnt[i] = 0; end
        do_reset();
        for (int n = 1; n <= limit; n++) begin
            @(negedge clk);
            for (int i = 0; i < 5; i++) begin
                if (ticks[i]) begin
                    cnt[i]++;
                    if (first[i] < 0) first[i] = n;
                    else if (second[i] < 0) second[i] = n;
                    if (prev[i]) dbl++;
                end
            end
            prev = ticks;
        end
        for (int i = 0; i < 5; i++) begin
            if (cd[i] >= 4'd1 && cd[i] <= 4'd12) begin
                check(first[i] == (6 << (cd[i] - 1)), "R3 first tick edge (R6 slot)",
                      first[i], 6 << (cd[i] - 1));
                check((second[i] - first[i]) == (6 << cd[i]), "R1 R2 tick period",
                      second[i] - first[i], 6 << cd[i]);
            end else begin
                check(cnt[i] == 0, "R4 disabled code ticks", cnt[i], 0);
            end
        end
        check(dbl == 0, "R5 back-to-back ticks", dbl, 0);
    endtask

    // R7 R8 R9 R10: external clock path of one consumer (1=t2, 2=sio, 3=adc).
    task automatic test_ext(input int which, input string req);
        int got;
        int pat [4];
        c_t1 = 4'd1; c_t2 = 4'd1; c_sio = 4'd1; c_adc = 4'd1; c_cko = 4'd1;
        t2_x = 1'b0; sio_x = 1'b0; adc_x = 1'b0;
        t2_sel = (which == 1); sio_sel = (which == 2); adc_cfg = (which == 3);
        do_reset();
        got = 0;
        for (int n = 0; n < 40; n++) begin @(negedge clk); if (ticks[which]) got++; end
        check(got == 0, {req, " internal tap ignored while external selected"}, got, 0);
        set_ext(which, 1'b1);
        for (int n = 0; n < 4; n++) begin @(negedge clk); pat[n] = ticks[which]; end
        check(pat[0] == 0 && pat[1] == 0 && pat[2] == 1 && pat[3] == 0,
              {req, " edge latency pattern"}, pat[0]*1000 + pat[1]*100 + pat[2]*10 + pat[3], 10);
        got = 0;
        for (int n = 0; n < 20; n++) begin @(negedge clk); if (ticks[which]) got++; end
        check(got == 0, "R8 held high level", got, 0);
        set_ext(which, 1'b0);
        got = 0;
        for (int n = 0; n < 20; n++) begin @(negedge clk); if (ticks[which]) got++; end
        check(got == 0, "R8 falling edge", got, 0);
        got = 0;
        for (int p = 0; p < 5; p++) begin
            set_ext(which, 1'b1);
            for (int n = 0; n < 4; n++) begin @(negedge clk); if (ticks[which]) got++; end
            set_ext(which, 1'b0);
            for (int n = 0; n < 4; n++) begin @(negedge clk); if (ticks[which]) got++; end
        end
        check(got == 5, {req, " one tick per external rise"}, got, 5);
        t2_sel = 1'b0; sio_sel = 1'b0; adc_cfg = 1'b0;
        got = 0;
        for (int n = 0; n < 14; n++) begin @(negedge clk); if (ticks[which]) got++; end
        check(got >= 1, {req, " internal tap back after deselect"}, got, 1);
    endtask

    initial begin
        test_reset_quiet();
        run_codes(4'd1, 4'd3, 4'd5, 4'd7, 4'd9, 4700);
        run_codes(4'd2, 4'd4, 4'd10, 4'd11, 4'd12, 36900);
        run_codes(4'd0, 4'd13, 4'd14, 4'd15, 4'd0, 2000);
        run_codes(4'd6, 4'd0, 4'd8, 4'd15, 4'd1, 3000);
        test_ext(1, "R7");
        test_ext(2, "R9");
        test_ext(3, "R10");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule